// File: doc/BRIEF.md
# Calibrated One-Second Prescaler

This block turns an oscillator-rate enable (one pulse per crystal cycle, nominally 32,768 per second) into a one-cycle tick once per second. It does not divide by a fixed count. It trims the long-term rate digitally: over a 64-minute correction cycle, the first second of selected minutes is shortened or lengthened by a fixed number of oscillator cycles. The size of the trim comes from a 5-bit magnitude and its direction from a sign bit, both in an 8-bit control byte.

The same control byte drives an open-drain pin, which is modelled as a pull-low enable. In frequency-test mode the pin toggles at 512 Hz, taken from the uncorrected low divider stage, so a frequency counter on the pin measures the raw crystal. Otherwise the pin shows a static level bit. A stop input freezes the prescaler. While stop is held, the divider is kept at zero and the second and minute positions keep their values.

The divider length (`DIV_BITS`) and the number of seconds per minute (`SECS_PER_MIN`) are parameters. Their defaults give the real-time rates. Smaller values compress the correction cycle for quick checks.

Top module: `cal_prescaler`

## Requirements
- R1: An uncorrected second lasts exactly 2^DIV_BITS asserted oscillator enables, with clock cycles that have `osc_en_i` low not counted. `tick_o` is high for exactly one clock cycle per second.
- R2: When ctrl_i[5] (sign) is 1, a corrected second lasts 256 oscillator enables fewer than nominal.
- R3: When ctrl_i[5] is 0, a corrected second lasts 128 oscillator enables more than nominal.
- R4: The magnitude is N = ctrl_i[4:0]. Minutes count from 0 to 63 and advance every SECS_PER_MIN ticks. The first second of minute m is corrected exactly when m < 2N, all other seconds are nominal, and N = 0 gives no correction.
- R5: Minutes 62 and 63 are never corrected, even with N = 31. After minute 63 the count returns to minute 0 and correction applies again.
- R6: When ctrl_i[6] (frequency test) is 1, `pin_low_o` toggles every 32 oscillator enables, whatever the sign and magnitude are and including across corrected seconds.
- R7: When ctrl_i[6] is 0, `pin_low_o` equals the inverse of ctrl_i[7] (level bit) one clock later. A level bit of 0 pulls the pin low.
- R8: While `rst` is high, `pin_low_o` and `tick_o` are 0, which leaves the pin released. After reset the first tick comes after a full second counted from the first enable sampled with reset low, at minute 0 and second 0.
- R9: While `stop_i` is high, no tick occurs and the divider is held at zero, so in test mode the pin settles released. The second and minute positions are kept. After release, the interrupted second restarts from zero at its full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en_i | input | 1 | One-cycle enable per oscillator cycle |
| stop_i | input | 1 | Freeze prescaler; divider held at zero |
| ctrl_i | input | 8 | [7] level bit, [6] frequency test, [5] sign, [4:0] magnitude |
| tick_o | output | 1 | One-cycle pulse per corrected second |
| pin_low_o | output | 1 | Pull-low enable of the open-drain pin |

## Verification
The length of each second is measured against a model computed in the bench. The configurations cover zero magnitude, small and large positive magnitudes, and small and large negative magnitudes. Together they separate the short, long and nominal second lengths and confirm that only first-of-minute seconds below minute 2N are corrected. A full compressed 64-minute cycle at magnitude 31 confirms that minutes 62 and 63 stay nominal and that correction resumes after the wrap. Separate runs check that the test-mode pin toggle spacing is unaffected across a shortened second, that gaps in the enable stretch a second only in clock time, and that a stop in mid-second keeps the minute position, which shows in the length of the seconds that follow.

// File: rtl/cal_prescale_pkg.sv
package cal_prescale_pkg;

    // low divider stage: uncorrected, 256 oscillator cycles per wrap
    localparam int FINE_BITS = 8;
    localparam int FT_BIT    = 5;   // toggles every 32 cycles -> 512 Hz
    localparam int MIN_BITS  = 6;   // 64-minute correction cycle
    localparam int CYCLE_MINS = 1 << MIN_BITS;

    localparam logic [FINE_BITS-1:0] FINE_LAST = '1;
    localparam logic [FINE_BITS-1:0] FINE_MID  = {1'b0, {(FINE_BITS-1){1'b1}}};

    typedef struct packed {
        logic       out_lvl;  // bit 7
        logic       ftest;    // bit 6
        logic       pos;      // bit 5: 1 = faster (shorter second)
        logic [4:0] mag;      // bits 4:0
    } cal_ctrl_t;

    typedef enum logic [1:0] {
        SEC_NORMAL = 2'd0,
        SEC_SHORT  = 2'd1,
        SEC_LONG   = 2'd2
    } sec_kind_t;

    function automatic sec_kind_t pick_kind(input logic first_sec,
                                            input logic [MIN_BITS-1:0] min_pos,
                                            input cal_ctrl_t c);
        if (first_sec && (min_pos < {c.mag, 1'b0}))
            return c.pos ? SEC_SHORT : SEC_LONG;
        return SEC_NORMAL;
    endfunction

endpackage

// File: rtl/cal_fine_div.sv
module cal_fine_div
    import cal_prescale_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stop_i,
    input  logic                 osc_en_i,
    output logic [FINE_BITS-1:0] fine_o
);
    logic [FINE_BITS-1:0] fine_q;

    always_ff @(posedge clk) begin
        if (rst || stop_i)
            fine_q <= '0;
        else if (osc_en_i)
            fine_q <= fine_q + 1'b1;
    end

    assign fine_o = fine_q;
endmodule

// File: rtl/cal_second_div.sv
module cal_second_div
    import cal_prescale_pkg::*;
#(
    parameter int DIV_BITS = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stop_i,
    input  logic                 osc_en_i,
    input  logic [FINE_BITS-1:0] fine_i,
    input  sec_kind_t            kind_i,
    output logic                 sec_end_o
);
    localparam int BLK_BITS = DIV_BITS - FINE_BITS;
    localparam int BLOCKS   = 1 << BLK_BITS;
    localparam int CNT_W    = BLK_BITS + 1;
    localparam logic [CNT_W-1:0] LAST_NORM  = CNT_W'(BLOCKS - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(BLOCKS - 2);

    logic [CNT_W-1:0] blk_q;
    logic             half_q;   // block boundary sits at mid-count of fine stage
    logic             pend_q;   // long second: waiting for the extra half block
    logic             evt, stretch;
    logic [CNT_W-1:0] last_blk;

    assign evt      = osc_en_i && !stop_i && (fine_i == (half_q ? FINE_MID : FINE_LAST));
    assign last_blk = (kind_i == SEC_SHORT) ? LAST_SHORT : LAST_NORM;
    assign sec_end_o = evt && (pend_q || ((blk_q == last_blk) && (kind_i != SEC_LONG)));
    assign stretch   = evt && !pend_q && (kind_i == SEC_LONG) && (blk_q == LAST_NORM);

    always_ff @(posedge clk) begin
        if (rst || stop_i) begin
            blk_q  <= '0;
            half_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (sec_end_o) begin
            blk_q  <= '0;
            pend_q <= 1'b0;
        end else if (stretch) begin
            pend_q <= 1'b1;
            half_q <= ~half_q;
        end else if (evt) begin
            blk_q <= blk_q + 1'b1;
        end
    end
endmodule

// File: rtl/cal_cycle_ctr.sv
module cal_cycle_ctr
    import cal_prescale_pkg::*;
#(
    parameter int SECS_PER_MIN = 60
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          sec_end_i,
    output logic [$clog2(SECS_PER_MIN)-1:0] sec_o,
    output logic [MIN_BITS-1:0]           min_o
);
    localparam int SEC_W = $clog2(SECS_PER_MIN);
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SECS_PER_MIN - 1);

    logic [SEC_W-1:0]    sec_q;
    logic [MIN_BITS-1:0] min_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q <= '0;
            min_q <= '0;
        end else if (sec_end_i) begin
            if (sec_q == SEC_LAST) begin
                sec_q <= '0;
                min_q <= min_q + 1'b1;   // wraps after CYCLE_MINS minutes
            end else begin
                sec_q <= sec_q + 1'b1;
            end
        end
    end

    assign sec_o = sec_q;
    assign min_o = min_q;
endmodule

// File: rtl/cal_prescaler.sv
module cal_prescaler
    import cal_prescale_pkg::*;
#(
    parameter int DIV_BITS     = 15,
    parameter int SECS_PER_MIN = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_en_i,
    input  logic       stop_i,
    input  logic [7:0] ctrl_i,
    output logic       tick_o,
    output logic       pin_low_o
);
    localparam int SEC_W = $clog2(SECS_PER_MIN);

    cal_ctrl_t            ctrl;
    logic [FINE_BITS-1:0] fine;
    logic [SEC_W-1:0]     sec_pos;
    logic [MIN_BITS-1:0]  min_pos;
    sec_kind_t            kind;
    logic                 sec_end;
    logic                 tick_q, pin_q;

    assign ctrl = cal_ctrl_t'(ctrl_i);
    assign kind = pick_kind(sec_pos == '0, min_pos, ctrl);

    cal_fine_div fine_i (
        .clk      (clk),
        .rst      (rst),
        .stop_i   (stop_i),
        .osc_en_i (osc_en_i),
        .fine_o   (fine)
    );

    cal_second_div #(.DIV_BITS(DIV_BITS)) sec_div_i (
        .clk       (clk),
        .rst       (rst),
        .stop_i    (stop_i),
        .osc_en_i  (osc_en_i),
        .fine_i    (fine),
        .kind_i    (kind),
        .sec_end_o (sec_end)
    );

    cal_cycle_ctr #(.SECS_PER_MIN(SECS_PER_MIN)) cyc_i (
        .clk       (clk),
        .rst       (rst),
        .sec_end_i (sec_end),
        .sec_o     (sec_pos),
        .min_o     (min_pos)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= 1'b0;
            pin_q  <= 1'b0;   // released, as with test off and level high
        end else begin
            tick_q <= sec_end;
            pin_q  <= ctrl.ftest ? fine[FT_BIT] : ~ctrl.out_lvl;
        end
    end

    assign tick_o    = tick_q;
    assign pin_low_o = pin_q;
endmodule

// File: rtl/cal_prescaler_chk.sv
module cal_prescaler_chk #(
    parameter int DIV_BITS     = 15,
    parameter int SECS_PER_MIN = 60
) (
    input logic clk,
    input logic rst,
    input logic osc_en_i,
    input logic stop_i,
    input logic ft_i,
    input logic out_i,
    input logic tick_o,
    input logic pin_low_o
);
    localparam int NOM = 1 << DIV_BITS;
    localparam int CW  = DIV_BITS + 2;
    localparam int SPM_CHK = SECS_PER_MIN;

    logic [CW-1:0] ev_cnt;

    always_ff @(posedge clk) begin
        if (rst || stop_i)
            ev_cnt <= '0;
        else if (tick_o)
            ev_cnt <= CW'(osc_en_i);
        else
            ev_cnt <= ev_cnt + CW'(osc_en_i);
    end

    AST_TICK_PULSE: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);  // R1

    AST_SEC_LENGTH: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> (ev_cnt == CW'(NOM) || ev_cnt == CW'(NOM - 256) || ev_cnt == CW'(NOM + 128)));  // R2

    AST_STOP_SILENT: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> !tick_o);  // R9

    AST_PIN_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !ft_i |=> (pin_low_o == !$past(out_i)));  // R7

    AST_PIN_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pin_low_o && !tick_o));  // R8

    initial begin
        AST_PARAM_OK: assert (DIV_BITS >= 9 && SPM_CHK >= 2);  // R1
    end
endmodule

bind cal_prescaler cal_prescaler_chk #(
    .DIV_BITS     (DIV_BITS),
    .SECS_PER_MIN (SECS_PER_MIN)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .osc_en_i  (osc_en_i),
    .stop_i    (stop_i),
    .ft_i      (ctrl_i[6]),
    .out_i     (ctrl_i[7]),
    .tick_o    (tick_o),
    .pin_low_o (pin_low_o)
);

// File: tb/cal_prescaler_tb_top.sv
module cal_prescaler_tb_top;
    localparam int DIVB = 9;
    localparam int SPM  = 2;
    localparam int NOM  = 1 << DIVB;
    localparam int NVEC = 6;

    // {sign, magnitude, seconds to measure}
    localparam logic [13:0] VECS [NVEC] = '{
        {1'b0, 5'd0,  8'd3},
        {1'b1, 5'd1,  8'd6},
        {1'b0, 5'd2,  8'd10},
        {1'b1, 5'd5,  8'd12},
        {1'b0, 5'd31, 8'd4},
        {1'b1, 5'd31, 8'd130}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_en = 1'b1;
    logic       stop = 1'b0;
    logic [7:0] ctrl = 8'h00;
    logic       tick, pin_low;
    int         cyc = 0;
    int         n_checks = 0;
    int         n_err = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cal_prescaler #(.DIV_BITS(DIVB), .SECS_PER_MIN(SPM)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .osc_en_i  (osc_en),
        .stop_i    (stop),
        .ctrl_i    (ctrl),
        .tick_o    (tick),
        .pin_low_o (pin_low)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int exp_len(input int k, input bit pos, input int mag);
        if ((k % SPM == 0) && (((k / SPM) % 64) < 2 * mag))
            return pos ? NOM - 256 : NOM + 128;
        return NOM;
    endfunction

    task automatic wait_tick();
        @(negedge clk);
        while (!tick) @(negedge clk);
    endtask

    task automatic do_reset(input logic [7:0] c, output int p);
        @(negedge clk);
        rst = 1'b1; stop = 1'b0; osc_en = 1'b1; ctrl = c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        p = cyc;
    endtask

    initial begin
        int p;
        // R8: reset state, with level bit 0 presented during reset
        ctrl = 8'h00;
        repeat (4) @(negedge clk);
        check(pin_low == 1'b0, "R8 pin released in reset", int'(pin_low), 0);
        check(tick == 1'b0, "R8 no tick in reset", int'(tick), 0);
        rst = 1'b0;
        @(negedge clk);
        check(pin_low == 1'b1, "R7 level 0 pulls low", int'(pin_low), 1);

        // vector table: second lengths (R1 R2 R3 R4 R5)
        for (int i = 0; i < NVEC; i++) begin
            bit pos;
            int mag, ns;
            pos = VECS[i][13];
            mag = int'(VECS[i][12:8]);
            ns  = int'(VECS[i][7:0]);
            do_reset({2'b10, pos, 5'(mag)}, p);
            for (int k = 0; k < ns; k++) begin
                int len;
                wait_tick();
                len = cyc - p;
                p = cyc;
                check(len == exp_len(k, pos, mag),
                      (mag == 0) ? "R1 nominal second" :
                      (ns > 64) ? "R5 full cycle second" :
                      pos ? "R2 R4 positive second" : "R3 R4 negative second",
                      len, exp_len(k, pos, mag));
            end
        end

        // R1: enable gaps do not count
        do_reset(8'h80, p);
        repeat (100) @(negedge clk);
        osc_en = 1'b0;
        repeat (50) @(negedge clk);
        osc_en = 1'b1;
        wait_tick();
        check(cyc - p == NOM + 50, "R1 gaps not counted", cyc - p, NOM + 50);

        // R6: test-mode toggle spacing across a shortened second
        do_reset(8'h7F, p);
        begin
            logic prev;
            int last;
            prev = pin_low;
            while (pin_low == prev) @(negedge clk);
            last = cyc;
            for (int j = 0; j < 20; j++) begin
                prev = pin_low;
                @(negedge clk);
                while (pin_low == prev) @(negedge clk);
                check(cyc - last == 32, "R6 test toggle spacing", cyc - last, 32);
                last = cyc;
            end
        end

        // R7: level bit follows when test mode off
        @(negedge clk); ctrl = 8'h80;
        @(negedge clk);
        check(pin_low == 1'b0, "R7 level 1 releases", int'(pin_low), 0);
        ctrl = 8'h00;
        @(negedge clk);
        check(pin_low == 1'b1, "R7 level 0 pulls low", int'(pin_low), 1);

        // R9: stop mid-second keeps minute position
        do_reset(8'h61, p);   // test on, positive, magnitude 1
        wait_tick();
        check(cyc - p == NOM - 256, "R9 pre-stop short second", cyc - p, NOM - 256);
        repeat (100) @(negedge clk);
        stop = 1'b1;
        begin
            int seen;
            seen = 0;
            repeat (1000) begin
                @(negedge clk);
                if (tick) seen++;
            end
            check(seen == 0, "R9 no tick while stopped", seen, 0);
            check(pin_low == 1'b0, "R9 divider held at zero", int'(pin_low), 0);
        end
        stop = 1'b0;
        p = cyc;
        wait_tick();
        check(cyc - p == NOM, "R9 restarted second full length", cyc - p, NOM);
        p = cyc;
        wait_tick();
        check(cyc - p == NOM - 256, "R9 minute kept, next corrected", cyc - p, NOM - 256);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule